// File: doc/BRIEF.md
# Indirect Management Register Access Sequencer

This block sits on the master side of a management bus. A requester hands it one request: a device address, a register selector, a read or write flag, a clause flag and 16-bit data. The block turns that request into the series of single-register transactions needed to reach a target that sits behind a command/data register pair. It drives an abstract transaction port with a request/done/error handshake and polls the target's busy flag at a fixed, programmable spacing until it clears or until a poll budget runs out. It returns the read data, a timeout flag or a bus-error flag with a one-cycle response strobe.

When the configured target address is zero, the target answers on every address. The block then skips indirection entirely and issues the request as one direct transaction. Clause 22 accesses use a single command per request. Clause 45 accesses first load the register address through the data register with an address operation and then run the read or write operation. The block generates no serial waveform and holds no target registers.

Top module: `mgmt_indirect_seq`

## Requirements
- R1: When `target_addr` is zero at acceptance, the request produces exactly one transaction with address `req_dev`, register `req_sub`, the request's write flag and, for a write, `req_wdata`. The data returned by a read appears on `rsp_rdata`.
- R2: When `target_addr` is non-zero, the first transaction is a read of the command register (register 0 at `target_addr`). No step follows a wait phase until a poll returns bit 15 clear.
- R3: A clause 22 write runs: wait, write `req_wdata` to the data register (register 1), write the command word, wait. The command word has bit 15 set, bit 12 set, bits 11:10 = 01, bits 9:5 = `req_dev` and bits 4:0 = `req_sub`.
- R4: A clause 22 read runs: wait, write the command word with bits 11:10 = 10 (bits 15 and 12 set), wait, read the data register. `rsp_rdata` takes the 16-bit value of that read.
- R5: A clause 45 access runs: wait, write `req_xreg` to the data register, write a command word with bit 15 set, bit 12 clear, bits 11:10 = 00, bits 9:5 = `req_dev` and bits 4:0 = `req_sub` (device), then wait. A write then writes `req_wdata` to the data register, writes the command with bits 11:10 = 01 and waits. A read writes the command with bits 11:10 = 11, waits and reads the data register.
- R6: After a poll returns busy, `tx_req` stays low for exactly `POLL_GAP` cycles before the next poll is requested.
- R7: If `MAX_POLLS` consecutive polls in one wait phase all return busy, the request ends with `rsp_timeout` and no further transaction. A poll that returns not-busy as the last allowed poll lets the sequence continue.
- R8: A transaction that completes with `tx_err` aborts the request with `rsp_buserr` and no further transaction. This holds even when the same poll would also have exhausted the poll budget; `rsp_timeout` then stays low.
- R9: `tx_req` and its fields hold steady until `tx_done`. `req_ready` is high only when idle. `rsp_valid` is a one-cycle pulse. A request raised while the block is busy is ignored.
- R10: After reset the block is idle: `req_ready` = 1, and `tx_req`, `rsp_valid`, `rsp_timeout` and `rsp_buserr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| target_addr | input | 5 | Bus address of the target; zero selects direct access |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_c45 | input | 1 | 1 = clause 45 access |
| req_dev | input | 5 | Device/PHY address inside the target |
| req_sub | input | 5 | Register (clause 22) or device type (clause 45) |
| req_xreg | input | 16 | Clause 45 register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_timeout | output | 1 | Busy flag never cleared within the poll budget |
| rsp_buserr | output | 1 | A transaction reported an error |
| rsp_rdata | output | 16 | Data of the most recent read |
| tx_req | output | 1 | Transaction request, held until `tx_done` |
| tx_write | output | 1 | Transaction direction, 1 = write |
| tx_phy | output | 5 | Transaction bus address |
| tx_reg | output | 5 | Transaction register number |
| tx_wdata | output | 16 | Transaction write data |
| tx_done | input | 1 | Transaction complete |
| tx_err | input | 1 | Transaction failed, valid with `tx_done` |
| tx_rdata | input | 16 | Transaction read data, valid with `tx_done` |

## Verification
On the last allowed poll, three things can coincide: the poll verdict, the budget expiry and a bus error. The bench puts a not-busy answer on poll number `MAX_POLLS` and expects success. It puts a busy answer there and expects a timeout after exactly `MAX_POLLS` polls. It puts a busy answer together with `tx_err` there and expects a bus error with the timeout flag low. A second request raised while a poll gap is counting is also driven, and the transaction log must show only the first request's sequence.

// File: rtl/isq_pkg.sv
package isq_pkg;

    localparam int ADDR_W   = 5;
    localparam int SUB_W    = 5;
    localparam int DATA_W   = 16;
    localparam int IDX_W    = 3;
    localparam int BUSY_BIT = 15;

    localparam logic [SUB_W-1:0] CMD_REG = SUB_W'(0);
    localparam logic [SUB_W-1:0] DAT_REG = SUB_W'(1);

    localparam logic [1:0] OPC_ADDR = 2'b00;
    localparam logic [1:0] OPC_WR   = 2'b01;
    localparam logic [1:0] OPC_RD22 = 2'b10;
    localparam logic [1:0] OPC_RD45 = 2'b11;

    typedef enum logic [2:0] {
        STP_END,
        STP_POLL,
        STP_PUT_DATA,
        STP_PUT_ADDR,
        STP_CMD_ADDR,
        STP_CMD_XFER,
        STP_GET_DATA,
        STP_DIRECT
    } step_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_GAP,
        ST_RESP
    } seq_st_e;

    typedef struct packed {
        logic              write;
        logic              c45;
        logic [ADDR_W-1:0] dev;
        logic [SUB_W-1:0]  sub;
        logic [DATA_W-1:0] xreg;
        logic [DATA_W-1:0] wdata;
        logic [ADDR_W-1:0] tgt;
    } req_t;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] phy;
        logic [SUB_W-1:0]  regn;
        logic [DATA_W-1:0] wdata;
    } xact_t;

    function automatic logic [DATA_W-1:0] cmd_word(
        input logic [1:0]        opc,
        input logic              c22,
        input logic [ADDR_W-1:0] dev,
        input logic [SUB_W-1:0]  sub
    );
        return {1'b1, 2'b00, c22, opc, dev, sub};
    endfunction

endpackage

// File: rtl/isq_step_plan.sv
module isq_step_plan
    import isq_pkg::*;
(
    input  logic             direct,
    input  logic             c45,
    input  logic             write,
    input  logic [IDX_W-1:0] idx,
    output step_e            step
);

    always_comb begin
        step = STP_END;
        if (direct) begin
            if (idx == IDX_W'(0)) step = STP_DIRECT;
        end else if (!c45) begin
            case (idx)
                IDX_W'(0): step = STP_POLL;
                IDX_W'(1): step = write ? STP_PUT_DATA : STP_CMD_XFER;
                IDX_W'(2): step = write ? STP_CMD_XFER : STP_POLL;
                IDX_W'(3): step = write ? STP_POLL     : STP_GET_DATA;
                default:   step = STP_END;
            endcase
        end else begin
            case (idx)
                IDX_W'(0): step = STP_POLL;
                IDX_W'(1): step = STP_PUT_ADDR;
                IDX_W'(2): step = STP_CMD_ADDR;
                IDX_W'(3): step = STP_POLL;
                IDX_W'(4): step = write ? STP_PUT_DATA : STP_CMD_XFER;
                IDX_W'(5): step = write ? STP_CMD_XFER : STP_POLL;
                IDX_W'(6): step = write ? STP_POLL     : STP_GET_DATA;
                default:   step = STP_END;
            endcase
        end
    end

endmodule

// File: rtl/isq_xact_map.sv
module isq_xact_map
    import isq_pkg::*;
(
    input  step_e step,
    input  req_t  rq,
    output xact_t xa
);

    logic [1:0] xfer_opc;

    always_comb begin
        if (rq.write)    xfer_opc = OPC_WR;
        else if (rq.c45) xfer_opc = OPC_RD45;
        else             xfer_opc = OPC_RD22;
    end

    always_comb begin
        xa = '0;
        case (step)
            STP_POLL: begin
                xa.phy  = rq.tgt;
                xa.regn = CMD_REG;
            end
            STP_PUT_DATA: begin
                xa.write = 1'b1;
                xa.phy   = rq.tgt;
                xa.regn  = DAT_REG;
                xa.wdata = rq.wdata;
            end
            STP_PUT_ADDR: begin
                xa.write = 1'b1;
                xa.phy   = rq.tgt;
                xa.regn  = DAT_REG;
                xa.wdata = rq.xreg;
            end
            STP_CMD_ADDR: begin
                xa.write = 1'b1;
                xa.phy   = rq.tgt;
                xa.regn  = CMD_REG;
                xa.wdata = cmd_word(OPC_ADDR, 1'b0, rq.dev, rq.sub);
            end
            STP_CMD_XFER: begin
                xa.write = 1'b1;
                xa.phy   = rq.tgt;
                xa.regn  = CMD_REG;
                xa.wdata = cmd_word(xfer_opc, !rq.c45, rq.dev, rq.sub);
            end
            STP_GET_DATA: begin
                xa.phy  = rq.tgt;
                xa.regn = DAT_REG;
            end
            STP_DIRECT: begin
                xa.write = rq.write;
                xa.phy   = rq.dev;
                xa.regn  = rq.sub;
                xa.wdata = rq.write ? rq.wdata : '0;
            end
            default: xa = '0;
        endcase
    end

endmodule

// File: rtl/isq_poll_ctrl.sv
module isq_poll_ctrl #(
    parameter int POLL_GAP  = 50000,
    parameter int MAX_POLLS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic busy_hit,
    input  logic in_gap,
    output logic poll_last,
    output logic gap_done
);

    localparam int PC_W = $clog2(MAX_POLLS + 1);
    localparam int GC_W = $clog2(POLL_GAP + 1);

    logic [PC_W-1:0] poll_cnt;
    logic [GC_W-1:0] gap_cnt;

    assign poll_last = (poll_cnt == PC_W'(MAX_POLLS - 1));
    assign gap_done  = (gap_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || clr)
            poll_cnt <= '0;
        else if (busy_hit && !poll_last)
            poll_cnt <= poll_cnt + PC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            gap_cnt <= '0;
        else if (busy_hit)
            gap_cnt <= GC_W'(POLL_GAP - 1);
        else if (in_gap && !gap_done)
            gap_cnt <= gap_cnt - GC_W'(1);
    end

    p_poll_bound_r7: assert property (@(posedge clk) disable iff (rst)
        poll_cnt < PC_W'(MAX_POLLS))
        else $error("poll counter beyond budget");

    p_gap_count_r6: assert property (@(posedge clk) disable iff (rst)
        in_gap && !gap_done |=> gap_cnt == $past(gap_cnt) - GC_W'(1))
        else $error("gap counter did not step down");

endmodule

// File: rtl/mgmt_indirect_seq.sv
module mgmt_indirect_seq
    import isq_pkg::*;
#(
    parameter int POLL_GAP  = 50000,
    parameter int MAX_POLLS = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] target_addr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_c45,
    input  logic [ADDR_W-1:0] req_dev,
    input  logic [SUB_W-1:0]  req_sub,
    input  logic [DATA_W-1:0] req_xreg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_timeout,
    output logic              rsp_buserr,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              tx_req,
    output logic              tx_write,
    output logic [ADDR_W-1:0] tx_phy,
    output logic [SUB_W-1:0]  tx_reg,
    output logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_done,
    input  logic              tx_err,
    input  logic [DATA_W-1:0] tx_rdata
);

    seq_st_e          st;
    req_t             cur;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_nxt;
    step_e            step_now;
    step_e            step_nxt;
    xact_t            xa;
    logic             direct;
    logic             fin_ok;
    logic             busy_hit;
    logic             poll_ok;
    logic             poll_last;
    logic             gap_done;
    logic             accept;

    assign direct   = (cur.tgt == '0);
    assign idx_nxt  = idx + IDX_W'(1);
    assign accept   = (st == ST_IDLE) && req_valid;
    assign fin_ok   = (st == ST_RUN) && tx_done && !tx_err;
    assign busy_hit = fin_ok && (step_now == STP_POLL) && tx_rdata[BUSY_BIT];
    assign poll_ok  = fin_ok && (step_now == STP_POLL) && !tx_rdata[BUSY_BIT];

    isq_step_plan u_plan_now (
        .direct (direct),
        .c45    (cur.c45),
        .write  (cur.write),
        .idx    (idx),
        .step   (step_now)
    );

    isq_step_plan u_plan_nxt (
        .direct (direct),
        .c45    (cur.c45),
        .write  (cur.write),
        .idx    (idx_nxt),
        .step   (step_nxt)
    );

    isq_xact_map u_map (
        .step (step_now),
        .rq   (cur),
        .xa   (xa)
    );

    isq_poll_ctrl #(
        .POLL_GAP  (POLL_GAP),
        .MAX_POLLS (MAX_POLLS)
    ) u_poll (
        .clk       (clk),
        .rst       (rst),
        .clr       (accept || poll_ok),
        .busy_hit  (busy_hit),
        .in_gap    (st == ST_GAP),
        .poll_last (poll_last),
        .gap_done  (gap_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            cur         <= '0;
            idx         <= '0;
            rsp_timeout <= 1'b0;
            rsp_buserr  <= 1'b0;
            rsp_rdata   <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur <= '{write: req_write, c45: req_c45, dev: req_dev,
                                 sub: req_sub, xreg: req_xreg, wdata: req_wdata,
                                 tgt: target_addr};
                        idx         <= '0;
                        rsp_timeout <= 1'b0;
                        rsp_buserr  <= 1'b0;
                        st          <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (tx_done) begin
                        if (tx_err) begin
                            rsp_buserr <= 1'b1;
                            st         <= ST_RESP;
                        end else if (busy_hit) begin
                            if (poll_last) begin
                                rsp_timeout <= 1'b1;
                                st          <= ST_RESP;
                            end else begin
                                st <= ST_GAP;
                            end
                        end else begin
                            if (step_now == STP_GET_DATA ||
                                (step_now == STP_DIRECT && !cur.write))
                                rsp_rdata <= tx_rdata;
                            idx <= idx_nxt;
                            if (step_nxt == STP_END) st <= ST_RESP;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_done) st <= ST_RUN;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (st == ST_IDLE);
    assign rsp_valid = (st == ST_RESP);
    assign tx_req    = (st == ST_RUN);
    assign tx_write  = xa.write;
    assign tx_phy    = xa.phy;
    assign tx_reg    = xa.regn;
    assign tx_wdata  = xa.wdata;

    p_direct_first_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && target_addr == '0 |=>
            tx_req && tx_phy == $past(req_dev) && tx_reg == $past(req_sub) &&
            tx_write == $past(req_write))
        else $error("direct request not passed through");

    p_poll_first_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && target_addr != '0 |=>
            tx_req && !tx_write && tx_reg == CMD_REG && tx_phy == $past(target_addr))
        else $error("indirect request did not start with a busy poll");

    p_timeout_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_timeout) |-> $past(tx_done && !tx_err && tx_rdata[BUSY_BIT]))
        else $error("timeout without a busy poll");

    p_buserr_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_buserr) |-> $past(tx_done && tx_err))
        else $error("bus error without a failed transaction");

    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        tx_req && !tx_done |=> tx_req && $stable(tx_write) && $stable(tx_phy) &&
            $stable(tx_reg) && $stable(tx_wdata))
        else $error("transaction request dropped or changed before done");

    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid && req_ready)
        else $error("response strobe longer than one cycle");

endmodule

// File: tb/sim_mgmt_indirect_seq.sv
module sim_mgmt_indirect_seq;

    localparam int CLK_P = 10;
    localparam int GAP   = 3;
    localparam int MAXP  = 4;
    localparam int LOGN  = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  target_addr = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_c45 = 1'b0;
    logic [4:0]  req_dev = '0;
    logic [4:0]  req_sub = '0;
    logic [15:0] req_xreg = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid, rsp_timeout, rsp_buserr;
    logic [15:0] rsp_rdata;
    logic        tx_req, tx_write;
    logic [4:0]  tx_phy, tx_reg;
    logic [15:0] tx_wdata;
    logic        tx_done = 1'b0;
    logic        tx_err = 1'b0;
    logic [15:0] tx_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit ended   = 0;

    // responder and target model state
    int          ncyc = 0;
    int          ntx = 0;
    bit          active = 0;
    int          lat_left = 0;
    int          m_lat = 0;
    int          m_busy = 0;
    int          m_err = -1;
    int          m_tgt = 0;
    int          busy_left = 0;
    logic [15:0] last_cmd = '0;
    logic [15:0] dreg = '0;
    bit          lg_w [LOGN];
    int          lg_p [LOGN];
    int          lg_r [LOGN];
    int          lg_d [LOGN];
    int          st_n [LOGN];
    int          dn_n [LOGN];

    // expected sequence
    int exp_n = 0;
    bit ex_w [LOGN];
    int ex_p [LOGN];
    int ex_r [LOGN];
    int ex_d [LOGN];

    // captured response
    bit          got_rsp;
    bit          got_to;
    bit          got_be;
    logic [15:0] got_rd;

    always #(CLK_P/2) clk = ~clk;

    mgmt_indirect_seq #(.POLL_GAP(GAP), .MAX_POLLS(MAXP)) u0 (
        .clk(clk), .rst(rst), .target_addr(target_addr),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_c45(req_c45), .req_dev(req_dev), .req_sub(req_sub),
        .req_xreg(req_xreg), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_buserr(rsp_buserr),
        .rsp_rdata(rsp_rdata),
        .tx_req(tx_req), .tx_write(tx_write), .tx_phy(tx_phy), .tx_reg(tx_reg),
        .tx_wdata(tx_wdata), .tx_done(tx_done), .tx_err(tx_err), .tx_rdata(tx_rdata)
    );

    function automatic logic [15:0] fnv(input logic [4:0] a, input logic [4:0] r);
        return {a, r, 6'h15} ^ 16'h3C00;
    endfunction

    function automatic int cmdw(input int opc, input int c22, input int dev, input int sub);
        return 32'h8000 | (c22 << 12) | (opc << 10) | (dev << 5) | sub;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, expv);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic respond();
        tx_err   = 1'b0;
        tx_rdata = 16'h0;
        if (ntx == m_err) begin
            tx_err   = 1'b1;
            tx_rdata = 16'h8000;
        end else if (m_tgt == 0) begin
            if (!tx_write) tx_rdata = fnv(tx_phy, tx_reg);
        end else if (tx_reg == 5'd0) begin
            if (tx_write) begin
                last_cmd  = tx_wdata;
                busy_left = m_busy;
                if ((tx_wdata[12] && tx_wdata[11:10] == 2'b10) ||
                    (!tx_wdata[12] && tx_wdata[11:10] == 2'b11))
                    dreg = fnv(tx_wdata[9:5], tx_wdata[4:0]);
            end else if (busy_left > 0) begin
                busy_left--;
                tx_rdata = {1'b1, last_cmd[14:0]};
            end else begin
                tx_rdata = {1'b0, last_cmd[14:0]};
            end
        end else if (tx_reg == 5'd1) begin
            if (tx_write) dreg = tx_wdata;
            else          tx_rdata = dreg;
        end
    endtask

    // transaction port responder with configurable latency
    initial begin
        forever begin
            @(negedge clk);
            ncyc++;
            if (rst) begin
                tx_done = 1'b0;
                tx_err  = 1'b0;
                active  = 0;
            end else if (tx_done) begin
                tx_done = 1'b0;
                tx_err  = 1'b0;
                active  = 0;
            end else if (tx_req && ntx < LOGN - 1) begin
                if (!active) begin
                    active     = 1;
                    lat_left   = m_lat;
                    lg_w[ntx]  = tx_write;
                    lg_p[ntx]  = int'(tx_phy);
                    lg_r[ntx]  = int'(tx_reg);
                    lg_d[ntx]  = int'(tx_wdata);
                    st_n[ntx]  = ncyc;
                end
                if (lat_left == 0) begin
                    respond();
                    dn_n[ntx] = ncyc;
                    ntx++;
                    tx_done = 1'b1;
                end else begin
                    lat_left--;
                end
            end
        end
    end

    task automatic push(input bit w, input int p, input int r, input int d);
        ex_w[exp_n] = w;
        ex_p[exp_n] = p;
        ex_r[exp_n] = r;
        ex_d[exp_n] = d;
        exp_n++;
    endtask

    task automatic push_wait(input int tgt, input int busy);
        for (int i = 0; i <= busy; i++) push(0, tgt, 0, 0);
    endtask

    task automatic build_exp(input int tgt, input bit w, input bit c45, input int dev,
                             input int sub, input int xreg, input int wd, input int busy);
        exp_n = 0;
        if (tgt == 0) begin
            push(w, dev, sub, w ? wd : 0);
        end else if (!c45) begin
            push_wait(tgt, busy);
            if (w) begin
                push(1, tgt, 1, wd);
                push(1, tgt, 0, cmdw(1, 1, dev, sub));
                push_wait(tgt, busy);
            end else begin
                push(1, tgt, 0, cmdw(2, 1, dev, sub));
                push_wait(tgt, busy);
                push(0, tgt, 1, 0);
            end
        end else begin
            push_wait(tgt, busy);
            push(1, tgt, 1, xreg);
            push(1, tgt, 0, cmdw(0, 0, dev, sub));
            push_wait(tgt, busy);
            if (w) begin
                push(1, tgt, 1, wd);
                push(1, tgt, 0, cmdw(1, 0, dev, sub));
                push_wait(tgt, busy);
            end else begin
                push(1, tgt, 0, cmdw(3, 0, dev, sub));
                push_wait(tgt, busy);
                push(0, tgt, 1, 0);
            end
        end
    endtask

    task automatic check_seq(input string rq);
        int mism = 0;
        if (ntx != exp_n) mism++;
        for (int i = 0; i < exp_n && i < ntx; i++) begin
            if (lg_w[i] != ex_w[i] || lg_p[i] != ex_p[i] || lg_r[i] != ex_r[i]) mism++;
            else if (ex_w[i] && lg_d[i] != ex_d[i]) mism++;
        end
        chk(mism == 0, rq, "transaction sequence (count)", ntx, exp_n);
    endtask

    task automatic run_op(input int tgt, input bit w, input bit c45, input int dev,
                          input int sub, input int xreg, input int wd, input int busy,
                          input int lat, input int err_at, input bit poke);
        int pokes = 0;
        m_busy    = busy;
        busy_left = busy;
        m_lat     = lat;
        m_err     = err_at;
        m_tgt     = tgt;
        last_cmd  = '0;
        dreg      = '0;
        ntx       = 0;
        got_rsp   = 0;
        got_to    = 0;
        got_be    = 0;
        got_rd    = '0;
        @(negedge clk);
        target_addr = 5'(tgt);
        req_write   = w;
        req_c45     = c45;
        req_dev     = 5'(dev);
        req_sub     = 5'(sub);
        req_xreg    = 16'(xreg);
        req_wdata   = 16'(wd);
        req_valid   = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            if (rsp_valid) begin
                got_rsp = 1;
                got_to  = rsp_timeout;
                got_be  = rsp_buserr;
                got_rd  = rsp_rdata;
                break;
            end
            if (poke && ntx >= 1 && pokes < 3) begin
                req_valid = 1'b1;
                req_write = ~w;
                req_dev   = 5'(dev + 1);
                req_sub   = 5'(sub + 3);
                pokes++;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        chk(req_ready == 1'b1, "R10", "req_ready after reset", int'(req_ready), 1);
        chk(!tx_req && !rsp_valid && !rsp_timeout && !rsp_buserr, "R10",
            "tx_req/rsp flags after reset",
            int'({tx_req, rsp_valid, rsp_timeout, rsp_buserr}), 0);

        // sweep: direct/indirect, clause, direction, busy depth
        for (int ti = 0; ti < 2; ti++) begin
            for (int c = 0; c < 2; c++) begin
                for (int w = 0; w < 2; w++) begin
                    for (int bi = 0; bi < 3; bi++) begin
                        int    tgt  = ti ? 9 : 0;
                        int    busy = (bi == 2) ? MAXP - 1 : bi;
                        int    dev  = 3 + bi * 7 + w;
                        int    sub  = (c * 8 + bi * 5 + 2) & 31;
                        int    xreg = 16'h1234 + bi * 16'h0101 + c;
                        int    wd   = 16'hA000 ^ (bi << 4) ^ (w << 8) ^ c;
                        string tag;
                        if (tgt == 0)    tag = "R1";
                        else if (c == 1) tag = "R5";
                        else if (w == 1) tag = "R3";
                        else             tag = "R4";
                        build_exp(tgt, w[0], c[0], dev, sub, xreg, wd, busy);
                        run_op(tgt, w[0], c[0], dev, sub, xreg, wd, busy, bi, -1, 0);
                        chk(got_rsp && !got_to && !got_be, tag, "response ok flags",
                            int'({got_rsp, got_to, got_be}), 4);
                        check_seq(tag);
                        if (w == 0)
                            chk(got_rd == fnv(5'(dev), 5'(sub)), tag, "read data",
                                int'(got_rd), int'(fnv(5'(dev), 5'(sub))));
                        if (tgt != 0) begin
                            chk(ntx > 0 && !lg_w[0] && lg_r[0] == 0 && lg_p[0] == tgt,
                                "R2", "first transaction is a command poll",
                                lg_r[0], 0);
                            if (busy > 0)
                                chk(st_n[1] - dn_n[0] == GAP + 1, "R6",
                                    "poll spacing", st_n[1] - dn_n[0], GAP + 1);
                        end
                        if (busy == MAXP - 1 && tgt != 0)
                            chk(got_rsp && !got_to, "R7", "not-busy on last allowed poll",
                                int'(got_to), 0);
                    end
                end
            end
        end

        // R7 timeout: busy never clears
        run_op(9, 1, 0, 4, 6, 0, 16'h5A5A, 1000, 1, -1, 0);
        chk(got_rsp && got_to && !got_be, "R7", "timeout flags",
            int'({got_rsp, got_to, got_be}), 6);
        chk(ntx == MAXP, "R7", "polls before timeout", ntx, MAXP);
        begin
            int bad = 0;
            for (int i = 0; i + 1 < ntx; i++)
                if (st_n[i + 1] - dn_n[i] != GAP + 1) bad++;
            chk(bad == 0, "R6", "all poll spacings in timeout run", bad, 0);
        end

        // R8 error on the final poll wins over the timeout
        run_op(9, 0, 0, 4, 6, 0, 0, 1000, 0, MAXP - 1, 0);
        chk(got_rsp && got_be && !got_to, "R8", "error beats timeout",
            int'({got_rsp, got_to, got_be}), 5);
        chk(ntx == MAXP, "R8", "transactions at error", ntx, MAXP);

        // R8 error at several points of a clause 45 write
        for (int e = 0; e < 3; e++) begin
            int at = (e == 0) ? 0 : ((e == 1) ? 2 : 5);
            run_op(9, 1, 1, 7, 3, 16'h0042, 16'hBEEF, 0, e, at, 0);
            chk(got_rsp && got_be && !got_to, "R8", "abort flags",
                int'({got_rsp, got_to, got_be}), 5);
            chk(ntx == at + 1, "R8", "no transaction after error", ntx, at + 1);
        end

        // R9 request raised while busy is ignored
        build_exp(9, 0, 0, 11, 13, 0, 0, 2);
        run_op(9, 0, 0, 11, 13, 0, 0, 2, 1, -1, 1);
        chk(got_rsp && !got_to && !got_be, "R9", "flags with overlapping request",
            int'({got_rsp, got_to, got_be}), 4);
        check_seq("R9");
        chk(got_rd == fnv(5'd11, 5'd13), "R9", "read data with overlapping request",
            int'(got_rd), int'(fnv(5'd11, 5'd13)));
        chk(req_ready == 1'b1 && !tx_req, "R9", "idle after response",
            int'({req_ready, tx_req}), 2);

        summary();
    end

endmodule